// File: doc/BRIEF.md
# Multi-Source Register Update Synchroniser

This block holds seven groups of double-buffered control registers for a multi-channel converter datapath. The groups are the offset pair AB, the offset pair CD, the quadrature correction for AB and for CD, the mixer for AB and for CD, and the oscillator-accumulator group. Software loads a shadow copy of each register through a plain write port with an address, 16-bit data and a strobe. A group's live (active) copy takes the shadow values only when one of the sync events enabled for that group fires. This lets several registers change together on a chosen event.

Each group has a 4-bit select field. Each bit enables one sync source, and the enabled sources are ORed. The sources are a software sync bit, an external sync pin, an output-strobe pin, and an automatic event raised by any register write. The oscillator group uses the input-strobe pin in place of the automatic event. That group also emits a one-cycle pulse for the accumulators whenever it updates. A routing bit chooses which synchronised pin drives the internal FIFO strobe path.

Top module: `sync_update_bank`

## Requirements
- R1: After reset the select word at 0x1E reads as 0x1111 and the one at 0x1F as 0x1140. The software sync bit is 0, and every shadow and active register is 0.
- R2: A write with address g*NREG+r loads shadow register r of group g. Groups are numbered 0 offset AB, 1 offset CD, 2 correction AB, 3 correction CD, 4 mixer AB, 5 mixer CD, 6 oscillator. Writes to any other address below 0x1E change no register.
- R3: A group's active registers change only on a clock edge where the group fires, and they then take the group's shadow values.
- R4: Select fields are bits 15:12, 11:8, 7:4 and 3:0 of 0x1E for groups 0 to 3. They are bits 15:12, 11:8 and 7:4 of 0x1F for groups 4 to 6.
- R5: In each field, bit 3 enables software sync, bit 2 the sync pin, bit 1 the output strobe and bit 0 the automatic event. A group fires if any enabled source has an event.
- R6: Any accepted write, whatever its address, raises an automatic event in the next cycle. A shadow write is therefore visible in the active copy one edge after the write edge.
- R7: Bit 1 of 0x1F is the software sync bit. It stays at the written value, and only its 0-to-1 change gives a single event.
- R8: The sync, output-strobe and input-strobe pins pass through two flops and are edge detected. A pin that is first seen high at edge k causes the group update at edge k+2.
- R9: In the oscillator group, select bit 0 enables the input-strobe pin instead of the automatic event. Its reset field 0100 enables only the sync pin.
- R10: osc_sync_o is high during exactly the cycles in which the oscillator group fires.
- R11: Bit 2 of 0x1F routes the pins to fifo_strobe_o. A value of 0 passes the synchronised input strobe, and a value of 1 passes the synchronised sync pin.
- R12: When a shadow write and an update of its group share an edge, the active copy takes the shadow value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Write strobe |
| addr_i | input | AW | Write address |
| wdata_i | input | DW | Write data |
| sync_i | input | 1 | External sync pin (asynchronous) |
| ostr_i | input | 1 | Output-strobe pin (asynchronous) |
| istr_i | input | 1 | Input-strobe pin (asynchronous) |
| act_o | output | 7*NREG*DW | Active registers; register r of group g at slice (g*NREG+r)*DW |
| osc_sync_o | output | 1 | Accumulator sync pulse from the oscillator group |
| fifo_strobe_o | output | 1 | Routed, synchronised strobe for the FIFO path |

## Verification
The assertions assume that the write port and the pins are stable around the active clock edge, and that reset is held for at least one edge. The pulse-width properties also rely on a pin level being seen by the first flop for whole cycles. The bench changes every input only on the falling edge, so each value is sampled once and cleanly. It holds the pins low during reset. Its random phase sends writes to mapped, unmapped and select addresses, together with short pin pulses, so that sources can collide in the same cycle.

// File: rtl/sync_bank_pkg.sv
package sync_bank_pkg;
  localparam int NGRP    = 7;
  localparam int OSC_GRP = 6;
  localparam int SEL_W   = 4;
  // source bit positions inside a select field
  localparam int SRC_SW   = 3;
  localparam int SRC_PIN  = 2;
  localparam int SRC_OSTR = 1;
  localparam int SRC_LOW  = 0;
  localparam logic [7:0]  ADDR_SEL_A = 8'h1E;
  localparam logic [7:0]  ADDR_SEL_B = 8'h1F;
  localparam logic [15:0] SEL_A_RST  = 16'h1111;
  localparam logic [11:0] SEL_B_RST  = 12'h114;
endpackage

// File: rtl/sync_event_src.sv
module sync_event_src #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic lvl_o,
  output logic ev_o
);
  logic [STAGES:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[STAGES-1:0], pin_i};
  end

  assign lvl_o = stg_q[STAGES-1];
  assign ev_o  = stg_q[STAGES-1] & ~stg_q[STAGES];

  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_o |=> !ev_o);
endmodule

// File: rtl/upd_group.sv
module upd_group #(
  parameter int          NREG = 2,
  parameter int          DW   = 16,
  parameter int          AW   = 8,
  parameter int unsigned BASE = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             fire_i,
  output logic [NREG*DW-1:0] act_o
);
  logic [NREG*DW-1:0] shd_q, act_q;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    localparam logic [AW-1:0] RADDR = AW'(BASE + r);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shd_q[r*DW +: DW] <= '0;
        act_q[r*DW +: DW] <= '0;
      end else begin
        if (we_i && addr_i == RADDR) shd_q[r*DW +: DW] <= wdata_i;
        // active takes pre-write shadow when both coincide
        if (fire_i) act_q[r*DW +: DW] <= shd_q[r*DW +: DW];
      end
    end
  end

  assign act_o = act_q;

  a_r3_hold_without_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_i |=> $stable(act_q));
  a_r12_copy_old_shadow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> act_q == $past(shd_q));
endmodule

// File: rtl/sync_update_bank.sv
module sync_update_bank
  import sync_bank_pkg::*;
#(
  parameter int NREG        = 2,
  parameter int DW          = 16,
  parameter int AW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [DW-1:0]           wdata_i,
  input  logic                    sync_i,
  input  logic                    ostr_i,
  input  logic                    istr_i,
  output logic [NGRP*NREG*DW-1:0] act_o,
  output logic                    osc_sync_o,
  output logic                    fifo_strobe_o
);
  localparam int SELCAT_W = 16 + 12;

  logic [15:0] sel_a_q;
  logic [11:0] sel_b_q;   // bits 15:4 of the second select word
  logic        route_q, sw_q, sw_d_q, auto_q;
  logic        sync_lvl, sync_ev, ostr_lvl, ostr_ev, istr_lvl, istr_ev;
  logic        sw_ev;
  logic [SELCAT_W-1:0] sel_cat;
  logic [NGRP-1:0]     fire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_a_q <= SEL_A_RST;
      sel_b_q <= SEL_B_RST;
      route_q <= 1'b0;
      sw_q    <= 1'b0;
      sw_d_q  <= 1'b0;
      auto_q  <= 1'b0;
    end else begin
      auto_q <= we_i;
      sw_d_q <= sw_q;
      if (we_i && addr_i == AW'(ADDR_SEL_A)) sel_a_q <= wdata_i[15:0];
      if (we_i && addr_i == AW'(ADDR_SEL_B)) begin
        sel_b_q <= wdata_i[15:4];
        route_q <= wdata_i[2];
        sw_q    <= wdata_i[1];
      end
    end
  end

  assign sw_ev   = sw_q & ~sw_d_q;
  assign sel_cat = {sel_a_q, sel_b_q};

  sync_event_src #(.STAGES(SYNC_STAGES)) i_sync_src (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(sync_i), .lvl_o(sync_lvl), .ev_o(sync_ev));
  sync_event_src #(.STAGES(SYNC_STAGES)) i_ostr_src (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(ostr_i), .lvl_o(ostr_lvl), .ev_o(ostr_ev));
  sync_event_src #(.STAGES(SYNC_STAGES)) i_istr_src (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(istr_i), .lvl_o(istr_lvl), .ev_o(istr_ev));

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [SEL_W-1:0] field, src;
    assign field = sel_cat[SELCAT_W-1-SEL_W*g -: SEL_W];
    if (g == OSC_GRP) begin : g_low_istr
      assign src = {sw_ev, sync_ev, ostr_ev, istr_ev};
    end else begin : g_low_auto
      assign src = {sw_ev, sync_ev, ostr_ev, auto_q};
    end
    assign fire[g] = |(field & src);

    upd_group #(.NREG(NREG), .DW(DW), .AW(AW), .BASE(g*NREG)) i_grp (
      .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
      .wdata_i(wdata_i), .fire_i(fire[g]),
      .act_o(act_o[g*NREG*DW +: NREG*DW]));
  end

  assign osc_sync_o    = fire[OSC_GRP];
  assign fifo_strobe_o = route_q ? sync_lvl : istr_lvl;

  a_r7_sw_single_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_ev |=> !sw_ev);
  a_r7_sw_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == AW'(ADDR_SEL_B)) |=> !sw_ev);
endmodule

// File: tb/test_sync_update_bank.sv
module test_sync_update_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NGRP = 7, NREG = 2, DW = 16, AW = 8;
  localparam int NR = NGRP * NREG;

  logic clk = 1'b0;
  logic rst_ni, we_i, sync_i, ostr_i, istr_i;
  logic [AW-1:0] addr_i;
  logic [DW-1:0] wdata_i;
  logic [NR*DW-1:0] act_o;
  logic osc_sync_o, fifo_strobe_o;

  sync_update_bank i_sync_update_bank (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .sync_i(sync_i), .ostr_i(ostr_i), .istr_i(istr_i), .act_o(act_o),
    .osc_sync_o(osc_sync_o), .fifo_strobe_o(fifo_strobe_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;
  // reference model
  logic [15:0] m_sh[NR], m_act[NR];
  logic [15:0] m_sel_a, m_sel_b;
  bit m_sw, m_sw_prev, m_wrote;
  bit qs[$], qo[$], qi[$];
  bit pin_s, pin_o, pin_i;

  task automatic model_reset();
    for (int k = 0; k < NR; k++) begin m_sh[k] = '0; m_act[k] = '0; end
    m_sel_a = 16'h1111; m_sel_b = 16'h1140;
    m_sw = 0; m_sw_prev = 0; m_wrote = 0;
    qs = '{0, 0, 0}; qo = '{0, 0, 0}; qi = '{0, 0, 0};
  endtask

  function automatic bit fires(int g);
    logic [31:0] cat = {m_sel_a, m_sel_b};
    logic [3:0] f = cat[31-4*g -: 4];
    bit ev_sw = m_sw & ~m_sw_prev;
    bit ev_s = qs[1] & ~qs[2];
    bit ev_o = qo[1] & ~qo[2];
    bit ev_i = qi[1] & ~qi[2];
    bit low = (g == 6) ? ev_i : m_wrote;
    return (f[3] & ev_sw) | (f[2] & ev_s) | (f[1] & ev_o) | (f[0] & low);
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    for (int k = 0; k < NR; k++)
      chk(tag, $sformatf("act[%0d]", k), 32'(act_o[k*DW +: DW]), 32'(m_act[k]));
    chk(tag, "osc_sync_o", 32'(osc_sync_o), 32'(fires(6)));
    chk(tag, "fifo_strobe_o", 32'(fifo_strobe_o), 32'(m_sel_b[2] ? qs[1] : qi[1]));
  endtask

  task automatic cyc(string tag, bit we, logic [7:0] a, logic [15:0] d);
    bit f[NGRP];
    @(negedge clk);
    we_i = we; addr_i = a; wdata_i = d; sync_i = pin_s; ostr_i = pin_o; istr_i = pin_i;
    for (int g = 0; g < NGRP; g++) f[g] = fires(g);
    for (int g = 0; g < NGRP; g++)
      if (f[g]) for (int r = 0; r < NREG; r++) m_act[g*NREG+r] = m_sh[g*NREG+r];
    m_sw_prev = m_sw;
    if (we) begin
      if (a < NR) m_sh[a] = d;
      else if (a == 8'h1E) m_sel_a = d;
      else if (a == 8'h1F) begin m_sel_b = d & 16'hFFF6; m_sw = d[1]; end
    end
    m_wrote = we;
    qs.push_front(pin_s); void'(qs.pop_back());
    qo.push_front(pin_o); void'(qo.pop_back());
    qi.push_front(pin_i); void'(qi.pop_back());
    @(posedge clk); #1;
    compare(tag);
  endtask

  task automatic idle(string tag, int n);
    for (int k = 0; k < n; k++) cyc(tag, 0, 8'h00, 16'h0000);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_ni = 0; we_i = 0; addr_i = '0; wdata_i = '0;
    sync_i = 0; ostr_i = 0; istr_i = 0; pin_s = 0; pin_o = 0; pin_i = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #1 compare("R1");
    @(negedge clk) rst_ni = 1;

    // R6: auto-sync via write; R9: osc group ignores it
    cyc("R6", 1, 8'h00, 16'hA5A5);
    cyc("R6", 0, 8'h00, 16'h0000);
    cyc("R9", 1, 8'h0C, 16'h1234);
    idle("R9", 2);
    // R2: unmapped write changes nothing
    cyc("R2", 1, 8'h15, 16'hFFFF);
    idle("R2", 2);

    // R4/R8: group 0 on sync pin only, others disabled
    cyc("R4", 1, 8'h1E, 16'h4000);
    cyc("R4", 1, 8'h01, 16'hBEEF);
    cyc("R4", 1, 8'h02, 16'hCAFE);
    idle("R4", 2);
    pin_s = 1; idle("R8", 4); pin_s = 0; idle("R8", 3);

    // R5: group 0 ostr, group 1 sw|sync; R9/R10: osc on istr
    cyc("R5", 1, 8'h1E, 16'h2C00);
    cyc("R9", 1, 8'h1F, 16'h0010);
    cyc("R5", 1, 8'h00, 16'h0F0F);
    cyc("R5", 1, 8'h0D, 16'h7777);
    pin_o = 1; idle("R5", 3); pin_o = 0; idle("R5", 2);
    pin_i = 1; idle("R10", 4); pin_i = 0; idle("R10", 2);

    // R7: software sync level, edge-only event
    cyc("R7", 1, 8'h03, 16'h5151);
    cyc("R7", 1, 8'h1F, 16'h0012);
    idle("R7", 2);
    cyc("R7", 1, 8'h02, 16'h6262);
    cyc("R7", 1, 8'h1F, 16'h0012);
    idle("R7", 2);
    cyc("R7", 1, 8'h1F, 16'h0010);
    cyc("R7", 1, 8'h1F, 16'h0012);
    idle("R7", 2);

    // R11: FIFO strobe routing
    cyc("R11", 1, 8'h1F, 16'h0004);
    pin_s = 1; idle("R11", 3); pin_s = 0; pin_i = 1; idle("R11", 3);
    cyc("R11", 1, 8'h1F, 16'h0000);
    idle("R11", 2); pin_i = 0; idle("R11", 3);

    // R12: back-to-back writes under auto-sync
    cyc("R12", 1, 8'h1E, 16'h1111);
    cyc("R12", 1, 8'h06, 16'h1010);
    cyc("R12", 1, 8'h06, 16'h2020);
    cyc("R12", 1, 8'h06, 16'h3030);
    idle("R12", 2);

    // R3/R5: random mixture
    for (int k = 0; k < 600; k++) begin
      int sel = $urandom_range(0, 9);
      logic [7:0] a = (sel == 0) ? 8'h1E : (sel == 1) ? 8'h1F : 8'($urandom_range(0, 17));
      if ($urandom_range(0, 5) == 0) pin_s = ~pin_s;
      if ($urandom_range(0, 5) == 0) pin_o = ~pin_o;
      if ($urandom_range(0, 5) == 0) pin_i = ~pin_i;
      cyc("R3", $urandom_range(0, 2) == 0, a, 16'($urandom));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule